// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator

The block watches a running time of day supplied by an external timekeeper as four BCD fields (seconds, minutes, hours, day of month). It holds four alarm registers in the same BCD layout. On every one-cycle second tick it compares the current time with the alarm. When they agree it sets a sticky alarm flag and, if the alarm interrupt is enabled, emits a one-cycle interrupt pulse.

Bit 7 of each alarm register is a mask flag. The flags of the date, hours and minutes registers cascade to pick the repeat rate: monthly, daily, hourly, every minute or every second. A byte-wide register port writes the alarm registers and the enable register and reads all registers back. Each alarm write is range checked, and a value that fails the check leaves the register unchanged. The calendar rollover of the time source is not part of this block.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset `irq` is low and every address reads 0x00.
- R2: A write to the alarm seconds register (address 0) or the alarm minutes register (address 1) is stored as the whole byte only when bits 6:0 are valid BCD in 00–59 (tens digit in bits 6:4, units digit in bits 3:0 at most 9). Any other write leaves the register unchanged.
- R3: A write to the alarm hours register (address 2) is stored as the whole byte only when bits 5:0 are valid BCD in 00–23. Any other write leaves the register unchanged.
- R4: A write to the alarm date register (address 3) is stored as the whole byte only when bits 4:0 are nonzero and the units digit in bits 3:0 is at most 9. Any other write leaves the register unchanged.
- R5: With all four mask bits (bit 7 of addresses 0–3) clear, a match requires the date, hours, minutes and seconds to all be equal. The alarm therefore recurs monthly.
- R6: With only the date mask set, a match requires the hours, minutes and seconds to be equal (daily).
- R7: With the date and hours masks set and the other two clear, a match requires the minutes and seconds to be equal (hourly).
- R8: With the date, hours and minutes masks set and the seconds mask clear, a match requires only the seconds to be equal (every minute).
- R9: Any other mask combination matches on every tick (every second).
- R10: A match is evaluated only in a cycle where `tick` is high. `irq` is high for exactly the one cycle after that edge, and only when enable bit 7 of address 4 is set. Address 4 reads back as {enable, 7'b0}.
- R11: A match sets the alarm flag regardless of the enable. Address 5 reads {1'b0, flag, 6'b0}. A read of address 5 clears the flag after that cycle, but a match in the same cycle keeps it set.
- R12: Writes to address 5 have no effect. Addresses 6 and 7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse once per second |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_date | input | 6 | Current day of month, BCD |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears the flag on address 5) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Alarm interrupt pulse |

## Verification
The comparator is tried in each of the five mask modes. For each mode the bench presents times that equal the alarm and times that differ in exactly one field. A field difference that fires in one mode and stays silent in another shows whether the mask cascade ignores the right fields.

Random time fields are biased half the time toward the alarm value, so matches and near-misses are frequent. Register writes are random, so valid and out-of-range BCD values both appear. Directed cases separate three things: a match off the tick, a match with the enable cleared (flag set but no pulse), and a flag read colliding with a new match.

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [6:0] cur_sec,
  input  logic [6:0] cur_min,
  input  logic [5:0] cur_hour,
  input  logic [5:0] cur_date,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);

  logic [7:0] al_sec, al_min, al_hour, al_date;
  logic       irq_en, flag;

  wire units_ok = wdata[3:0] <= 4'd9;
  wire sm_ok    = units_ok && wdata[6:4] <= 3'd5;
  wire hour_ok  = units_ok && (wdata[5:4] < 2'd2 || (wdata[5:4] == 2'd2 && wdata[3:0] <= 4'd3));
  wire date_ok  = units_ok && wdata[4:0] != 5'd0;

  wire [3:0] mask = {al_date[7], al_hour[7], al_min[7], al_sec[7]};
  wire eq_sec  = cur_sec  == al_sec[6:0];
  wire eq_min  = cur_min  == al_min[6:0];
  wire eq_hour = cur_hour == al_hour[5:0];
  wire eq_date = cur_date == {1'b0, al_date[4:0]};

  logic hit_fields;
  always_comb begin
    case (mask)
      4'b0000: hit_fields = eq_date && eq_hour && eq_min && eq_sec;
      4'b1000: hit_fields = eq_hour && eq_min && eq_sec;
      4'b1100: hit_fields = eq_min && eq_sec;
      4'b1110: hit_fields = eq_sec;
      default: hit_fields = 1'b1;
    endcase
  end
  wire hit = tick && hit_fields;
  wire flag_rd = rd_en && addr == 3'd5;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      al_sec  <= 8'h00;
      al_min  <= 8'h00;
      al_hour <= 8'h00;
      al_date <= 8'h00;
      irq_en  <= 1'b0;
      flag    <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= hit && irq_en;
      if (hit) flag <= 1'b1;
      else if (flag_rd) flag <= 1'b0;
      if (wr_en) begin
        case (addr)
          3'd0: if (sm_ok)   al_sec  <= wdata;
          3'd1: if (sm_ok)   al_min  <= wdata;
          3'd2: if (hour_ok) al_hour <= wdata;
          3'd3: if (date_ok) al_date <= wdata;
          3'd4: irq_en <= wdata[7];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      3'd0: rdata = al_sec;
      3'd1: rdata = al_min;
      3'd2: rdata = al_hour;
      3'd3: rdata = al_date;
      3'd4: rdata = {irq_en, 7'b0};
      3'd5: rdata = {1'b0, flag, 6'b0};
      default: rdata = 8'h00;
    endcase
  end

  assert_irq_after_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tick) && $past(irq_en));
  assert_irq_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
  assert_flag_rise_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick));
  assert_flag_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !tick) |=> !flag);
  assert_bad_sec_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && wdata[3:0] > 4'd9) |=> $stable(al_sec));
  assert_bad_hour_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2 && wdata[5:4] == 2'd3) |=> $stable(al_hour));
  assert_zero_date_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3 && wdata[4:0] == 5'd0) |=> $stable(al_date));

endmodule

// File: tb/rtc_alarm_match_test.sv
module rtc_alarm_match_test;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic       rst_n, tick, wr_en, rd_en, irq;
  logic [6:0] cur_sec, cur_min;
  logic [5:0] cur_hour, cur_date;
  logic [2:0] addr;
  logic [7:0] wdata, rdata;

  rtc_alarm_match uut (.clk(clk), .rst_n(rst_n), .tick(tick), .cur_sec(cur_sec),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_sec, m_min, m_hour, m_date;
  logic m_en, m_flag;

  function automatic bit ok_sm(logic [7:0] v);
    return v[3:0] <= 9 && int'(v[6:4]) * 10 + int'(v[3:0]) <= 59;
  endfunction
  function automatic bit ok_h(logic [7:0] v);
    return v[3:0] <= 9 && int'(v[5:4]) * 10 + int'(v[3:0]) <= 23;
  endfunction
  function automatic bit ok_d(logic [7:0] v);
    return v[3:0] <= 9 && v[4:0] != 0;
  endfunction

  function automatic logic [7:0] model_read(logic [2:0] a);
    case (a)
      3'd0: return m_sec;
      3'd1: return m_min;
      3'd2: return m_hour;
      3'd3: return m_date;
      3'd4: return {m_en, 7'b0};
      3'd5: return {1'b0, m_flag, 6'b0};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string read_tag(logic [2:0] a);
    case (a)
      3'd0, 3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R10";
      3'd5: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [3:0] masks();
    return {m_date[7], m_hour[7], m_min[7], m_sec[7]};
  endfunction

  function automatic string mode_tag();
    case (masks())
      4'b0000: return "R5";
      4'b1000: return "R6";
      4'b1100: return "R7";
      4'b1110: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic bit model_hit(logic [6:0] s, logic [6:0] mi, logic [5:0] h, logic [5:0] d);
    bit es = s == m_sec[6:0];
    bit em = mi == m_min[6:0];
    bit eh = h == m_hour[5:0];
    bit ed = d == {1'b0, m_date[4:0]};
    case (masks())
      4'b0000: return ed && eh && em && es;
      4'b1000: return eh && em && es;
      4'b1100: return em && es;
      4'b1110: return es;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(bit t, logic [6:0] s, logic [6:0] mi, logic [5:0] h, logic [5:0] d,
                     bit w, bit r, logic [2:0] a, logic [7:0] wd);
    bit hit, exp_irq;
    string tg;
    @(negedge clk);
    tick = t; cur_sec = s; cur_min = mi; cur_hour = h; cur_date = d;
    wr_en = w; rd_en = r; addr = a; wdata = wd;
    #1;
    if (r) check(read_tag(a), rdata, model_read(a));
    hit = t && model_hit(s, mi, h, d);
    exp_irq = hit && m_en;
    tg = t ? mode_tag() : "R10";
    @(posedge clk); #1;
    check(tg, {7'b0, irq}, {7'b0, exp_irq});
    if (r && a == 3'd5) m_flag = 1'b0;
    if (hit) m_flag = 1'b1;
    if (w) begin
      case (a)
        3'd0: if (ok_sm(wd)) m_sec = wd;
        3'd1: if (ok_sm(wd)) m_min = wd;
        3'd2: if (ok_h(wd)) m_hour = wd;
        3'd3: if (ok_d(wd)) m_date = wd;
        3'd4: m_en = wd[7];
        default: ;
      endcase
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] v);
    cyc(0, 7'h00, 7'h00, 6'h00, 6'h01, 1, 0, a, v);
  endtask
  task automatic rd(logic [2:0] a);
    cyc(0, 7'h00, 7'h00, 6'h00, 6'h01, 0, 1, a, 8'h00);
  endtask
  task automatic tk(logic [6:0] s, logic [6:0] mi, logic [5:0] h, logic [5:0] d);
    cyc(1, s, mi, h, d, 0, 0, 3'd0, 8'h00);
  endtask

  function automatic logic [7:0] rnd_bcd(int tens_max);
    return {4'(($urandom % (tens_max + 1))), 4'(($urandom % 10))};
  endfunction

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; tick = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    cur_sec = 0; cur_min = 0; cur_hour = 0; cur_date = 0;
    m_sec = 0; m_min = 0; m_hour = 0; m_date = 0; m_en = 0; m_flag = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {7'b0, irq}, 8'h00);
    for (int i = 0; i < 8; i++) begin
      addr = 3'(i); #1;
      check("R1", rdata, 8'h00);
    end
    rst_n = 1;

    wr(0, 8'h60); rd(0);
    wr(0, 8'h45); rd(0);
    wr(0, 8'h5A); rd(0);
    wr(1, 8'h30); rd(1);
    wr(2, 8'h24); rd(2);
    wr(2, 8'h23); rd(2);
    wr(3, 8'h00); rd(3);
    wr(3, 8'h15); rd(3);
    wr(4, 8'h80); rd(4);

    tk(7'h45, 7'h30, 6'h23, 6'h15);
    tk(7'h45, 7'h30, 6'h23, 6'h14);
    rd(5); rd(5);
    cyc(0, 7'h45, 7'h30, 6'h23, 6'h15, 0, 0, 0, 0);
    rd(5);
    wr(4, 8'h00);
    tk(7'h45, 7'h30, 6'h23, 6'h15);
    rd(5);
    wr(4, 8'h80);
    cyc(1, 7'h45, 7'h30, 6'h23, 6'h15, 0, 1, 3'd5, 8'h00);
    rd(5);

    wr(3, 8'h95);
    tk(7'h45, 7'h30, 6'h23, 6'h02);
    tk(7'h45, 7'h30, 6'h22, 6'h02);
    wr(2, 8'hA3);
    tk(7'h45, 7'h30, 6'h05, 6'h02);
    tk(7'h45, 7'h31, 6'h05, 6'h02);
    wr(1, 8'hB0);
    tk(7'h45, 7'h12, 6'h05, 6'h02);
    tk(7'h44, 7'h12, 6'h05, 6'h02);
    wr(0, 8'hC5);
    tk(7'h01, 7'h12, 6'h05, 6'h02);
    wr(3, 8'h15); wr(2, 8'h23); wr(1, 8'h30);
    tk(7'h02, 7'h00, 6'h00, 6'h01);

    wr(5, 8'hFF); rd(5);
    rd(6); rd(7);

    for (int n = 0; n < 4000; n++) begin
      bit t = ($urandom % 2) == 0;
      bit w = ($urandom % 4) == 0;
      bit r = !w && ($urandom % 3) == 0;
      logic [2:0] a = 3'($urandom % 8);
      logic [7:0] wd = ($urandom % 2) ? 8'($urandom) : {1'($urandom), rnd_bcd(5)[6:0]};
      logic [6:0] s  = ($urandom % 2) ? m_sec[6:0] : rnd_bcd(5)[6:0];
      logic [6:0] mi = ($urandom % 2) ? m_min[6:0] : rnd_bcd(5)[6:0];
      logic [5:0] h  = ($urandom % 2) ? m_hour[5:0] : rnd_bcd(2)[5:0];
      logic [5:0] d  = ($urandom % 2) ? {1'b0, m_date[4:0]} : rnd_bcd(3)[5:0];
      cyc(t, s, mi, h, d, w, r, a, wd);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule